// File: doc/BRIEF.md
# Three-Port Integer Register File with Multiplexer-Tree Readout

This block is the architectural register file of a five-stage integer pipeline: 32 words of `DATA_W` bits, two independent read ports for the register-access stage and one write port for the write-back stage. Each read port is a fixed three-level multiplexer tree. A 4:1 level is steered by address bits [1:0]. A second 4:1 level is steered by bits [3:2]. A final 2:1 level is steered by bit [4]. The readout stays purely digital, with no sensing circuitry.

The write address is decoded into 31 one-hot write lines, one per register 1 to 31. Entry 0 has no storage and always reads zero. The clock cycle is treated as two halves: write-back lands in the first half and operand reads happen in the second. The pipeline therefore sees a value written in a cycle when it reads the same register in that cycle, and no forwarding path is needed for that case. Storage is captured on the rising edge. A bypass at the tree output returns the incoming write data when the written register is the one being read.

Top module: `rf_mux3p`

## Requirements
- R1: While `rst_n` is low, and after it is released, registers 1 to 31 hold zero, so every read address returns zero until that register is written.
- R2: With `wr_en` high at a rising clock edge, `wr_data` is stored in the register at `wr_addr` (1 to 31). In every later cycle, both read ports return that value for that address until the register is written again.
- R3: With `wr_en` low, no register changes, whatever `wr_addr` and `wr_data` carry.
- R4: Address 0 always reads zero on both ports. A write to address 0 has no effect, including during the cycle it is presented.
- R5: When `wr_en` is high and `wr_addr` is nonzero, a read port whose address equals `wr_addr` returns `wr_data` in that same cycle.
- R6: The two read ports are independent. Any pair of addresses, including equal ones, returns the addressed contents on both ports in the same cycle.
- R7: At most one internal write line is active in any cycle, and none is active when `wr_en` is low or `wr_addr` is 0.
- R8: The read data is selected by the full 5-bit address. Bits [1:0] pick within a group of four, bits [3:2] pick the group of four, and bit [4] picks the half. All 32 addresses therefore reach distinct registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears registers 1 to 31 |
| wr_en | input | 1 | Write-back enable |
| wr_addr | input | 5 | Register written |
| wr_data | input | DATA_W | Value written |
| ra_addr | input | 5 | Read port A address |
| ra_data | output | DATA_W | Read port A data |
| rb_addr | input | 5 | Read port B address |
| rb_data | output | DATA_W | Read port B data |

## Verification
On every cycle, the assertions check four things. The write lines must be one-hot or idle, and idle when writing is disabled or aimed at register 0. Address 0 must read zero on each port. A same-cycle read of the register being written must return the write data. A register written in one cycle must read back unchanged in the next cycle unless it is overwritten. Only the bench's sweeps can show the rest. These are the clearing by reset across the whole file, and that a disabled write leaves all 31 registers untouched. They also include that every one of the 1024 address pairs reaches its own register through the tree, and that long random mixes of writes and reads agree with a reference array.

// File: rtl/rf_pkg.sv
package rf_pkg;
    // Fan-in of each multiplexer level, first (address LSBs) to last
    localparam int unsigned LVL1_FAN = 4;
    localparam int unsigned LVL2_FAN = 4;
    localparam int unsigned LVL3_FAN = 2;

    localparam int unsigned NREGS   = LVL1_FAN * LVL2_FAN * LVL3_FAN;
    localparam int unsigned ADDR_W  = $clog2(NREGS);
    localparam int unsigned LVL1_W  = $clog2(LVL1_FAN);
    localparam int unsigned LVL2_W  = $clog2(LVL2_FAN);
    localparam int unsigned LVL3_W  = $clog2(LVL3_FAN);
    localparam int unsigned LVL1_CNT = NREGS / LVL1_FAN;      // first-level muxes
    localparam int unsigned LVL2_CNT = LVL1_CNT / LVL2_FAN;   // second-level muxes

    typedef logic [ADDR_W-1:0] rf_addr_t;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
    import rf_pkg::*;
(
    input  logic              wr_en,
    input  rf_addr_t          wr_addr,
    output logic [NREGS-1:1]  wr_line
);
    // One line per writable register; entry 0 has no line at all
    for (genvar gi = 1; gi < NREGS; gi++) begin : g_line
        assign wr_line[gi] = wr_en && (wr_addr == ADDR_W'(gi));
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import rf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NREGS-1:1]               wr_line,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NREGS-1:0][DATA_W-1:0]   regs_o
);
    // Entry 0 is a constant zero: no flops, no write line
    assign regs_o[0] = '0;

    for (genvar gi = 1; gi < NREGS; gi++) begin : g_reg
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_line[gi]) begin
                word_q <= wr_data;
            end
        end

        assign regs_o[gi] = word_q;
    end
endmodule

// File: rtl/rf_mux_tree.sv
module rf_mux_tree
    import rf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [NREGS-1:0][DATA_W-1:0] regs_i,
    input  rf_addr_t                     sel_i,
    output logic [DATA_W-1:0]            q_o
);
    localparam int unsigned L2_LO = LVL1_W;
    localparam int unsigned L3_LO = LVL1_W + LVL2_W;

    logic [LVL1_W-1:0] sel1;
    logic [LVL2_W-1:0] sel2;
    logic [LVL3_W-1:0] sel3;

    assign sel1 = sel_i[LVL1_W-1:0];
    assign sel2 = sel_i[L2_LO +: LVL2_W];
    assign sel3 = sel_i[L3_LO +: LVL3_W];

    logic [LVL1_CNT-1:0][DATA_W-1:0] lvl1_q;
    logic [LVL2_CNT-1:0][DATA_W-1:0] lvl2_q;

    // Level 1: each node picks one of LVL1_FAN adjacent registers
    for (genvar gn = 0; gn < LVL1_CNT; gn++) begin : g_l1
        always_comb begin
            lvl1_q[gn] = regs_i[gn*LVL1_FAN];
            for (int k = 0; k < LVL1_FAN; k++) begin
                if (sel1 == LVL1_W'(k)) begin
                    lvl1_q[gn] = regs_i[gn*LVL1_FAN + k];
                end
            end
        end
    end

    // Level 2: each node picks one of LVL2_FAN first-level outputs
    for (genvar gn = 0; gn < LVL2_CNT; gn++) begin : g_l2
        always_comb begin
            lvl2_q[gn] = lvl1_q[gn*LVL2_FAN];
            for (int k = 0; k < LVL2_FAN; k++) begin
                if (sel2 == LVL2_W'(k)) begin
                    lvl2_q[gn] = lvl1_q[gn*LVL2_FAN + k];
                end
            end
        end
    end

    // Level 3: final 2:1 stage on the address MSB
    always_comb begin
        q_o = lvl2_q[0];
        for (int k = 0; k < LVL3_FAN; k++) begin
            if (sel3 == LVL3_W'(k)) begin
                q_o = lvl2_q[k];
            end
        end
    end
endmodule

// File: rtl/rf_mux3p.sv
module rf_mux3p
    import rf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [4:0]        ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [4:0]        rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [NREGS-1:1]             wr_line;
    logic [NREGS-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]            tree_a;
    logic [DATA_W-1:0]            tree_b;

    rf_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_line (wr_line)
    );

    rf_storage #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_line (wr_line),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    rf_mux_tree #(.DATA_W(DATA_W)) u_tree_a (
        .regs_i (regs),
        .sel_i  (ra_addr),
        .q_o    (tree_a)
    );

    rf_mux_tree #(.DATA_W(DATA_W)) u_tree_b (
        .regs_i (regs),
        .sel_i  (rb_addr),
        .q_o    (tree_b)
    );

    // First-half write, second-half read: the read sees the write in flight.
    // The decoded line already excludes entry 0 and disabled writes.
    logic [NREGS-1:0] line_full;
    assign line_full = {wr_line, 1'b0};

    assign ra_data = line_full[ra_addr] ? wr_data : tree_a;
    assign rb_data = line_full[rb_addr] ? wr_data : tree_b;
endmodule

// File: rtl/rf_mux3p_chk.sv
module rf_mux3p_chk
    import rf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [4:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [4:0]        ra_addr,
    input logic [DATA_W-1:0] ra_data,
    input logic [4:0]        rb_addr,
    input logic [DATA_W-1:0] rb_data,
    input logic [NREGS-1:1]  wr_line
);
    assert_wr_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_line));

    assert_wr_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr == 5'd0) |-> (wr_line == '0));

    assert_zero_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == 5'd0) |-> (ra_data == '0));

    assert_zero_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_addr == 5'd0) |-> (rb_data == '0));

    assert_bypass_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 5'd0 && wr_addr == ra_addr) |-> (ra_data == wr_data));

    assert_bypass_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 5'd0 && wr_addr == rb_addr) |-> (rb_data == wr_data));

    assert_persist_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) != 5'd0
         && ra_addr == $past(wr_addr) && !(wr_en && wr_addr == ra_addr))
        |-> (ra_data == $past(wr_data)));

    assert_persist_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) != 5'd0
         && rb_addr == $past(wr_addr) && !(wr_en && wr_addr == rb_addr))
        |-> (rb_data == $past(wr_data)));
endmodule

bind rf_mux3p rf_mux3p_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ra_addr (ra_addr),
    .ra_data (ra_data),
    .rb_addr (rb_addr),
    .rb_data (rb_data),
    .wr_line (wr_line)
);

// File: tb/rf_mux3p_tb.sv
module rf_mux3p_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [4:0]    ra_addr = '0;
    logic [4:0]    rb_addr = '0;
    logic [DW-1:0] ra_data;
    logic [DW-1:0] rb_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] model [32];
    logic [31:0] lfsr = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_mux3p #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ra_addr(ra_addr), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_data(rb_data)
    );

    function automatic logic [DW-1:0] pattern(int idx, int salt);
        return (32'h0101_0101 * idx) ^ (32'hA5C3_0000 + salt * 32'h0001_0007);
    endfunction

    function automatic logic [31:0] next_rand(logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        return x ^ (x << 5);
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expect_rd(logic we, logic [4:0] wa,
                                                logic [DW-1:0] wd, logic [4:0] ra);
        if (ra == 5'd0) return '0;
        if (we && wa == ra) return wd;
        return model[ra];
    endfunction

    // One cycle: drive after the falling edge, compare mid-low-phase, commit at rise
    task automatic step(string req, logic we, logic [4:0] wa, logic [DW-1:0] wd,
                        logic [4:0] ra, logic [4:0] rb);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; ra_addr = ra; rb_addr = rb;
        #1;
        check({req, " port A"}, ra_data, expect_rd(we, wa, wd, ra));
        check({req, " port B"}, rb_data, expect_rd(we, wa, wd, rb));
        @(posedge clk);
        if (we && wa != 5'd0) model[wa] = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R1: every register reads zero after reset
        for (int i = 0; i < 32; i++) step("R1 reset clear", 1'b0, 5'd0, '0, 5'(i), 5'(31 - i));

        // R2/R4/R5: write every address, reading the target in the same cycle
        for (int i = 0; i < 32; i++)
            step("R5 same-cycle", 1'b1, 5'(i), pattern(i, 1), 5'(i), 5'(i == 0 ? 0 : i - 1));

        // R4: a write to 0 leaves it zero in later cycles
        step("R4 zero write", 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
        step("R4 zero after", 1'b0, 5'd0, '0, 5'd0, 5'd1);

        // R6/R8/R2: every address pair on both ports
        for (int a = 0; a < 32; a++)
            for (int b = 0; b < 32; b++)
                step("R8 pair sweep", 1'b0, 5'(a ^ b), pattern(b, 9), 5'(a), 5'(b));

        // R3: disabled writes to every address change nothing
        for (int i = 0; i < 32; i++)
            step("R3 disabled write", 1'b0, 5'(i), ~pattern(i, 1), 5'(i), 5'(31 - i));
        for (int i = 0; i < 32; i++)
            step("R3 readback", 1'b0, 5'd0, '0, 5'(i), 5'(i));

        // R2/R5/R6: random mix with frequent address collisions
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] wa, ra, rb;
            lfsr = next_rand(lfsr);
            wa = lfsr[4:0];
            ra = lfsr[7] ? wa : lfsr[12:8];
            rb = lfsr[13] ? wa : lfsr[18:14];
            step("R2 random", lfsr[20] | lfsr[21], wa, next_rand(lfsr ^ 32'h9E37_79B9), ra, rb);
        end

        // R1: reset in mid-run clears the written file
        do_reset();
        for (int i = 0; i < 32; i++) step("R1 re-reset", 1'b0, 5'd0, '0, 5'(31 - i), 5'(i));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule